// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one 16-bit timer channel with a small byte-addressed register port. A divider picks a count rate of 1, 4, 16 or 64 system clocks, and the counter steps on the rising, falling or both edges of that divided clock. It steps only while this channel's bit in a start vector is high, and only while the mode register selects normal counting. The start vector is shared with other channels.

Two general registers, A and B, are compared with the counter on every count tick. A hit sets a status flag. A hit can also drive one of two compare output pins and can reset the counter, which turns the channel into a periodic tick source. An interrupt line is raised while any enabled flag is set. Software clears a flag with two steps: it reads the flag as 1, then writes 0 to that bit.

Top module: `cmt_chan`

## Requirements
- R1: After reset, every register reads 0, both compare outputs are low and irq is low.
- R2: Byte registers sit at offsets 0 (control), 1 (mode), 2 (output control), 4 (interrupt enable) and 5 (status), and are read back on rdata[7:0]. The 16-bit counter is at offset 6, general register A at 8 and general register B at 10. Written values read back unchanged, except the status register.
- R3: Control bits 2:0 select the count-clock divider: 0 gives 1, 1 gives 4, 2 gives 16, 3 gives 64. Codes 4 to 7 give no ticks. With the rising-edge setting the counter advances by exactly K over any K*N clock cycles.
- R4: Control bits 4:3 select the edge: 0 is rising, 1 is falling, 2 is both, and 3 behaves as rising. With both edges and a divider of 4 or more, the counter advances by 2K over K*N cycles. With divide-by-1, every cycle is a tick whatever the edge setting.
- R5: The counter holds while start_vec[CH_INDEX] is 0, whatever the other start bits are. It also holds while mode bits 3:0 are not 0.
- R6: Control bits 7:5 select the clear source. A value of 1 clears on a register A hit and 2 clears on a register B hit, so the period is the register value plus 1 ticks. Every other value never clears, and the counter wraps from 0xFFFF to 0.
- R7: A hit is a tick on which the counter equals a general register. A hit on A sets status bit 0 and a hit on B sets status bit 1.
- R8: A status flag clears only when a write of 0 to its bit follows a status read that saw it as 1. Any status write disarms all pending clears. Writing 1, or writing 0 without a prior read, leaves the flag set.
- R9: If the clearing write and a new hit on the same flag fall in one cycle, the flag stays set.
- R10: Output-control bits 3:0 drive out_a and bits 7:4 drive out_b. Codes 0 and 4 leave the pin alone. On the write, codes 1 to 3 force the pin low and codes 5 to 7 force it high. After that, each hit of the pin's register clears the pin (1 and 5), sets it (2 and 6) or toggles it (3 and 7).
- R11: irq is high exactly when status bit 0 and enable bit 0 are both set, or status bit 1 and enable bit 1 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_vec | input | START_W | Shared start bits, one per channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms status clears) |
| addr | input | 4 | Register byte offset |
| wdata | input | 16 | Write data; byte registers use bits 7:0 |
| rdata | output | 16 | Read data for addr, combinational |
| out_a | output | 1 | Compare output driven by register A hits |
| out_b | output | 1 | Compare output driven by register B hits |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: the software flag-clear write and a new compare hit on that flag. The bench provokes the collision with the channel stopped. It loads the counter with register A's value and arms the clear with a status read. Then, before a single clock edge, it raises the start bit and issues the write of 0. The flag must still read 1 afterwards. The counter must have gone to 0, and a second read-then-write-0 must clear the flag.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;
    localparam int DIV_W  = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_MODE = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_IOC  = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_GRA  = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_GRB  = 4'd10;

    typedef struct packed {
        logic [2:0] clr;
        logic [1:0] edg;
        logic [2:0] psc;
    } ctrl_t;

    typedef enum logic [1:0] {CLR_NONE, CLR_ON_A, CLR_ON_B} clr_src_e;
    typedef enum logic [1:0] {EDG_RISE, EDG_FALL, EDG_BOTH, EDG_RISE2} edg_e;
    typedef enum logic [1:0] {ACT_KEEP, ACT_LOW, ACT_HIGH, ACT_TOG} act_e;

    function automatic clr_src_e clr_decode(input logic [2:0] f);
        case (f)
            3'd1:    return CLR_ON_A;
            3'd2:    return CLR_ON_B;
            default: return CLR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] psc,
    input  logic [1:0] edg,
    output logic       tick_raw
);
    logic [DIV_W-1:0] div_q;
    logic             lvl, lvl_q, rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            div_q <= div_q + 1'b1;
            lvl_q <= lvl;
        end
    end

    // divided clock of period 4, 16, 64: counter bit 1, 3, 5
    always_comb begin
        case (psc)
            3'd1:    lvl = div_q[1];
            3'd2:    lvl = div_q[3];
            3'd3:    lvl = div_q[5];
            default: lvl = 1'b0;
        endcase
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;

    always_comb begin
        if (psc == 3'd0) begin
            tick_raw = 1'b1;
        end else if (psc > 3'd3) begin
            tick_raw = 1'b0;
        end else begin
            case (edg_e'(edg))
                EDG_FALL: tick_raw = fall;
                EDG_BOTH: tick_raw = rise | fall;
                default:  tick_raw = rise;
            endcase
        end
    end
endmodule

// File: rtl/cmt_outctl.sv
module cmt_outctl
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [3:0] code_new,
    input  logic [3:0] code,
    input  logic       hit,
    output logic       pin
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= 1'b0;
        end else if (load) begin
            if (code_new[1:0] != 2'd0) pin <= code_new[2];
        end else if (hit) begin
            case (act_e'(code[1:0]))
                ACT_LOW:  pin <= 1'b0;
                ACT_HIGH: pin <= 1'b1;
                ACT_TOG:  pin <= ~pin;
                default:  pin <= pin;
            endcase
        end
    end
endmodule

// File: rtl/cmt_flags.sv
module cmt_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hit,
    input  logic         rd_stat,
    input  logic         wr_stat,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] flags
);
    logic [N-1:0] armed_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic clr_ok;
        assign clr_ok = wr_stat && armed_q[i] && !wbits[i];
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i]   <= 1'b0;
                armed_q[i] <= 1'b0;
            end else begin
                flags[i] <= hit[i] | (flags[i] & ~clr_ok);
                if (wr_stat)      armed_q[i] <= 1'b0;
                else if (rd_stat) armed_q[i] <= flags[i];
            end
        end
    end
endmodule

// File: rtl/cmt_chan.sv
module cmt_chan
    import cmt_pkg::*;
#(
    parameter int START_W  = 3,
    parameter int CH_INDEX = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [START_W-1:0] start_vec,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [15:0]        wdata,
    output logic [15:0]        rdata,
    output logic               out_a,
    output logic               out_b,
    output logic               irq
);
    localparam int NCMP = 2;

    ctrl_t            ctrl_q;
    logic [7:0]       mode_q, ioc_q, ien_q;
    logic [CNT_W-1:0] cnt_q, gra_q, grb_q;
    logic [NCMP-1:0]  hit, flags, pins;
    logic             tick_raw, run, tick, clr_hit, ioc_wr;
    clr_src_e         src;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mode_q <= '0;
            ioc_q  <= '0;
            ien_q  <= '0;
            gra_q  <= '0;
            grb_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_CTRL: ctrl_q <= ctrl_t'(wdata[7:0]);
                OFS_MODE: mode_q <= wdata[7:0];
                OFS_IOC:  ioc_q  <= wdata[7:0];
                OFS_IEN:  ien_q  <= wdata[7:0];
                OFS_GRA:  gra_q  <= wdata;
                OFS_GRB:  grb_q  <= wdata;
                default: ;
            endcase
        end
    end

    cmt_prescale u_psc (
        .clk(clk), .rst(rst), .psc(ctrl_q.psc), .edg(ctrl_q.edg),
        .tick_raw(tick_raw)
    );

    assign run  = start_vec[CH_INDEX] && (mode_q[3:0] == 4'd0);
    assign tick = tick_raw && run;
    assign hit  = {tick && (cnt_q == grb_q), tick && (cnt_q == gra_q)};
    assign src  = clr_decode(ctrl_q.clr);
    assign clr_hit = (src == CLR_ON_A && hit[0]) || (src == CLR_ON_B && hit[1]);

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (wr_en && addr == OFS_CNT) cnt_q <= wdata;
        else if (tick)                    cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
    end

    assign ioc_wr = wr_en && (addr == OFS_IOC);

    for (genvar i = 0; i < NCMP; i++) begin : g_out
        cmt_outctl u_oc (
            .clk(clk), .rst(rst), .load(ioc_wr),
            .code_new(wdata[4*i +: 4]), .code(ioc_q[4*i +: 4]),
            .hit(hit[i]), .pin(pins[i])
        );
    end
    assign out_a = pins[0];
    assign out_b = pins[1];

    cmt_flags #(.N(NCMP)) u_flg (
        .clk(clk), .rst(rst), .hit(hit),
        .rd_stat(rd_en && addr == OFS_STAT),
        .wr_stat(wr_en && addr == OFS_STAT),
        .wbits(wdata[NCMP-1:0]), .flags(flags)
    );

    assign irq = |(flags & ien_q[NCMP-1:0]);

    always_comb begin
        case (addr)
            OFS_CTRL: rdata = {8'h00, ctrl_q};
            OFS_MODE: rdata = {8'h00, mode_q};
            OFS_IOC:  rdata = {8'h00, ioc_q};
            OFS_IEN:  rdata = {8'h00, ien_q};
            OFS_STAT: rdata = {{(16-NCMP){1'b0}}, flags};
            OFS_CNT:  rdata = cnt_q;
            OFS_GRA:  rdata = gra_q;
            OFS_GRB:  rdata = grb_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmt_chan_chk.sv
module cmt_chan_chk
    import cmt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_bit,
    input logic             wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic             tick,
    input logic [7:0]       ctrl,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] gra,
    input logic [CNT_W-1:0] grb,
    input logic [1:0]       flags,
    input logic [7:0]       ien,
    input logic             irq
);
    logic cnt_wr, st_wr;
    assign cnt_wr = wr_en && addr == OFS_CNT;
    assign st_wr  = wr_en && addr == OFS_STAT;

    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (cnt == '0 && flags == 2'b00 && !irq));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && cnt != gra && cnt != grb) |=> cnt == $past(cnt) + 16'd1);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!start_bit && !cnt_wr) |=> $stable(cnt));

    p_clear_a_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && ctrl[7:5] == 3'd1 && cnt == gra) |=> cnt == '0);

    p_flag_a_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == gra) |=> flags[0]);

    p_flag_b_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == grb) |=> flags[1]);

    p_hit_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == gra && st_wr) |=> flags[0]);

    p_irq_r11: assert property (@(posedge clk) disable iff (rst)
        ((flags[0] && ien[0]) || (flags[1] && ien[1])) |-> irq);
endmodule

bind cmt_chan cmt_chan_chk u_chk (
    .clk(clk), .rst(rst), .start_bit(start_vec[CH_INDEX]),
    .wr_en(wr_en), .addr(addr), .tick(tick), .ctrl(ctrl_q),
    .cnt(cnt_q), .gra(gra_q), .grb(grb_q), .flags(flags),
    .ien(ien_q), .irq(irq)
);

// File: tb/cmt_chan_tb.sv
module cmt_chan_tb;
    localparam logic [2:0] RUN = 3'b010;

    logic        clk = 1'b0, rst = 1'b1;
    logic [2:0]  start_vec = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        out_a, out_b, irq;
    int checks = 0, errors = 0;
    bit done = 0;

    cmt_chan u_dut (
        .clk(clk), .rst(rst), .start_vec(start_vec), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .out_a(out_a), .out_b(out_b), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        addr = a; rd_en = 1'b1; #1 v = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [15:0] v);
        addr = a; #1 v = rdata;
    endtask

    task automatic run_n(input int n);
        start_vec = RUN;
        repeat (n) @(posedge clk);
        @(negedge clk);
        start_vec = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        foreach (u_dut.OFS_CTRL[i]) ;
        for (int a = 0; a < 12; a++) begin
            peek(4'(a), v);
            chk("R1 reg", v, 0);
        end
        chk("R1 pins", {out_a, out_b, irq}, 0);

        // R2 register round trip
        wr(4'd0, 16'h00A5); peek(4'd0, v); chk("R2 ctrl", v, 16'h00A5);
        wr(4'd1, 16'h0033); peek(4'd1, v); chk("R2 mode", v, 16'h0033);
        wr(4'd4, 16'h00C0); peek(4'd4, v); chk("R2 ien", v, 16'h00C0);
        wr(4'd6, 16'h1234); peek(4'd6, v); chk("R2 cnt", v, 16'h1234);
        wr(4'd8, 16'hBEEF); peek(4'd8, v); chk("R2 gra", v, 16'hBEEF);
        wr(4'd10, 16'hCAFE); peek(4'd10, v); chk("R2 grb", v, 16'hCAFE);
        wr(4'd0, 0); wr(4'd1, 0); wr(4'd4, 0);
        wr(4'd8, 16'hFFFF); wr(4'd10, 16'hFFFF); wr(4'd6, 0);

        // R3 R4 divider and edge sweep
        for (int p = 0; p < 4; p++) begin
            for (int e = 0; e < 3; e++) begin
                int n, k, exp;
                n = 1 << (2 * p); k = 3;
                exp = (p != 0 && e == 2) ? 2 * k : k;
                wr(4'd0, 16'((e << 3) | p));
                start_vec = RUN;
                repeat (2) @(negedge clk);
                peek(4'd6, v0);
                repeat (k * n) @(negedge clk);
                peek(4'd6, v);
                start_vec = '0;
                chk($sformatf("R3 R4 psc%0d edg%0d", p, e), 16'(v - v0), exp);
            end
        end
        wr(4'd0, 16'h0004); start_vec = RUN; peek(4'd6, v0);
        repeat (40) @(negedge clk); peek(4'd6, v); start_vec = '0;
        chk("R3 code4 no tick", 16'(v - v0), 0);

        // R5 start bit and mode gating
        wr(4'd0, 0);
        peek(4'd6, v0); start_vec = 3'b101;
        repeat (20) @(negedge clk); peek(4'd6, v); start_vec = '0;
        chk("R5 foreign start bits", 16'(v - v0), 0);
        wr(4'd1, 16'h0001); peek(4'd6, v0); run_n(20); peek(4'd6, v);
        chk("R5 mode nonzero", 16'(v - v0), 0);
        wr(4'd1, 0);

        // R6 R7 clear source sweep
        for (int s = 1; s <= 2; s++) begin
            for (int g = 0; g < 5; g++) begin
                wr(4'd0, 16'(s << 5));
                wr(s == 1 ? 4'd8 : 4'd10, 16'(g));
                wr(s == 1 ? 4'd10 : 4'd8, 16'hFFFF);
                wr(4'd6, 0);
                run_n(2 * g + 3);
                peek(4'd6, v);
                chk($sformatf("R6 src%0d period g=%0d", s, g), v, (2 * g + 3) % (g + 1));
                peek(4'd5, v);
                chk($sformatf("R7 flag src%0d", s), v[s-1], 1);
            end
        end
        wr(4'd0, 0); wr(4'd6, 16'hFFFE); run_n(3); peek(4'd6, v);
        chk("R6 wrap", v, 1);
        wr(4'd0, 16'h0060); wr(4'd8, 5); wr(4'd6, 4); run_n(3); peek(4'd6, v);
        chk("R6 code3 no clear", v, 7);

        // R8 flag clear protocol (both flags set here)
        wr(4'd5, 0); peek(4'd5, v); chk("R8 write0 unread", v, 3);
        rd(4'd5, v); wr(4'd5, 16'h0003); peek(4'd5, v); chk("R8 write1", v, 3);
        wr(4'd5, 0); peek(4'd5, v); chk("R8 disarmed", v, 3);
        rd(4'd5, v); wr(4'd5, 16'h0002); peek(4'd5, v); chk("R8 clear bit0 only", v, 2);
        rd(4'd5, v); wr(4'd5, 0); peek(4'd5, v); chk("R8 clear all", v, 0);

        // R9 collision of clearing write with new hit
        wr(4'd0, 16'h0020); wr(4'd8, 5); wr(4'd10, 16'hFFFF);
        wr(4'd6, 5); run_n(1);
        wr(4'd6, 5); rd(4'd5, v);
        addr = 4'd5; wdata = 0; wr_en = 1'b1; start_vec = RUN;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; start_vec = '0;
        peek(4'd5, v); chk("R9 hit wins", v[0], 1);
        peek(4'd6, v); chk("R9 counter cleared", v, 0);
        rd(4'd5, v); wr(4'd5, 0); peek(4'd5, v); chk("R9 later clear", v, 0);

        // R11 interrupt
        wr(4'd4, 1); #1 chk("R11 no flag", irq, 0);
        wr(4'd6, 5); run_n(1); #1 chk("R11 A enabled", irq, 1);
        wr(4'd4, 2); #1 chk("R11 A masked", irq, 0);
        wr(4'd4, 3); #1 chk("R11 both enables", irq, 1);
        rd(4'd5, v); wr(4'd5, 0); #1 chk("R11 cleared", irq, 0);
        wr(4'd4, 0);

        // R10 compare outputs
        wr(4'd0, 16'h0020); wr(4'd8, 3); wr(4'd10, 2); wr(4'd6, 0);
        wr(4'd2, 16'h0027); #1 chk("R10 init", {out_b, out_a}, 2'b01);
        run_n(3); #1 chk("R10 B set", {out_b, out_a}, 2'b11);
        run_n(1); #1 chk("R10 A toggle", {out_b, out_a}, 2'b10);
        run_n(4); #1 chk("R10 A toggle again", {out_b, out_a}, 2'b11);
        wr(4'd2, 0); #1 chk("R10 keep on write", {out_b, out_a}, 2'b11);
        run_n(4); #1 chk("R10 keep on hit", {out_b, out_a}, 2'b11);
        wr(4'd2, 16'h0051); #1 chk("R10 init2", {out_b, out_a}, 2'b10);
        run_n(3); #1 chk("R10 B clear", {out_b, out_a}, 2'b00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule